// File: doc/BRIEF.md
# Bus and Local Wake-up Detector

This block watches the sampled output of a single-wire bus receiver and the sampled level of a local wake input, and tells the mode controller when the node should wake. A bus wake is a complete dominant pulse. The bus first goes from recessive to dominant. It then stays dominant for longer than a minimum hold time. It then goes back to recessive. A local wake is a change of the wake input in either direction that stays stable for a debounce time.

Time is counted in ticks of a fixed-rate enable `tick_i`. The hold and debounce limits are parameters given in ticks, so the same RTL serves any tick rate. The bus path is armed while the node is in sleep or in standby. The local path is armed in sleep only. Each accepted wake gives a one-cycle strobe. It also sets a sticky flag that records the source. The flags stay set until the mode controller reports entry into a normal mode.

Top module: `lin_wake_detector`

## Requirements
- R1: Right after reset, `wake_pulse_o`, `bus_wake_o` and `local_wake_o` are all 0.
- R2: The receiver bit uses 0 for dominant and 1 for recessive. While armed, a recessive-to-dominant edge, then at least BUS_HOLD_TICKS+1 rising clock edges that sample dominant with `tick_i` high, then a recessive sample make `wake_pulse_o` and `bus_wake_o` go high at the clock edge that samples the recessive level.
- R3: A dominant phase that returns recessive before it has been sampled BUS_HOLD_TICKS+1 times produces no wake. The next falling edge starts a fresh attempt.
- R4: The bus path is armed when `sleep_i` or `standby_i` is 1. With both low, a dominant pulse of any length produces no pulse and no flag.
- R5: Dominant time advances only on cycles with `tick_i` high. A dominant phase during which `tick_i` stays low never qualifies.
- R6: A dominant level that was already present when arming began does not count. The sequence must begin with a recessive-to-dominant edge seen while the path is armed.
- R7: In sleep, a change of `wake_pin_i` in either direction that is sampled at DEBOUNCE_TICKS+1 consecutive clock edges with `tick_i` high sets `local_wake_o` and pulses `wake_pulse_o` at the last of those edges. The new level then becomes the reference.
- R8: Outside sleep, changes on `wake_pin_i` produce no pulse and no local flag. The reference level follows the pin, so entering sleep does not trigger a wake by itself.
- R9: If `wake_pin_i` returns to the reference level before the debounce completes, the count is discarded. A later change needs the full debounce again.
- R10: `bus_wake_o` and `local_wake_o` stay set until `normal_entry_i` is sampled high. Both are 0 after that edge, and the clear wins over a wake in the same cycle.
- R11: `wake_pulse_o` is high for exactly one cycle per accepted wake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Fixed-rate time base enable |
| sleep_i | input | 1 | Node is in sleep |
| standby_i | input | 1 | Node is in standby |
| normal_entry_i | input | 1 | Mode controller is entering a normal mode; clears the flags |
| rx_i | input | 1 | Sampled bus receiver bit, 0 = dominant |
| wake_pin_i | input | 1 | Sampled local wake input level |
| wake_pulse_o | output | 1 | One-cycle wake strobe |
| bus_wake_o | output | 1 | Sticky flag: wake came from the bus |
| local_wake_o | output | 1 | Sticky flag: wake came from the local input |

## Verification
Directed bus pulses of exactly BUS_HOLD_TICKS and BUS_HOLD_TICKS+1 dominant samples separate an off-by-one in the hold counter from a correct limit. A long dominant phase with the tick held low, and one that begins before arming, show whether the counter is gated and whether an edge is required. Wake input changes of both polarities are held for DEBOUNCE_TICKS and DEBOUNCE_TICKS+1 samples, or bounced back and retried, to show whether the debounce restarts. Random rounds mix the modes with pulse and hold lengths near both limits, and each round ends with a clear, so the sticky flags are tested in every mode.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;
  typedef enum logic [1:0] {
    BW_IDLE = 2'd0,
    BW_LOW  = 2'd1,
    BW_HELD = 2'd2
  } bw_state_e;
endpackage

// File: rtl/bus_wake_seq.sv
module bus_wake_seq
  import lin_wake_pkg::*;
#(
  parameter int HOLD_TICKS = 100,
  parameter int CW         = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic armed_i,
  input  logic rx_i,
  output logic hit_o
);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  bw_state_e      state_q;
  logic [CW-1:0]  cnt_q;
  logic           rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BW_IDLE;
      cnt_q   <= '0;
      rx_q    <= 1'b1;
    end else begin
      rx_q <= rx_i;
      if (!armed_i) begin
        state_q <= BW_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          BW_IDLE: if (rx_q && !rx_i) begin
            state_q <= BW_LOW;
            cnt_q   <= '0;
          end
          BW_LOW: begin
            if (rx_i) begin
              state_q <= BW_IDLE;  // released too early: discard
            end else if (tick_i) begin
              if (cnt_q == LAST) state_q <= BW_HELD;
              else               cnt_q   <= cnt_q + 1'b1;
            end
          end
          BW_HELD: if (rx_i) state_q <= BW_IDLE;
          default: state_q <= BW_IDLE;
        endcase
      end
    end
  end

  assign hit_o = armed_i && (state_q == BW_HELD) && rx_i;
endmodule

// File: rtl/local_wake_filt.sv
module local_wake_filt #(
  parameter int DEB_TICKS = 30,
  parameter int CW        = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic armed_i,
  input  logic wake_i,
  output logic hit_o
);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic          ref_q;
  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic          diff;

  assign diff  = (wake_i != ref_q);
  assign hit_o = armed_i && pend_q && diff && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!armed_i) begin
      ref_q  <= wake_i;  // track level outside sleep
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!diff) begin
      pend_q <= 1'b0;    // bounced back: restart
      cnt_q  <= '0;
    end else if (!pend_q) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        ref_q  <= wake_i;
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wake_flag_reg.sv
module wake_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_hit_i,
  input  logic loc_hit_i,
  input  logic clr_i,
  output logic pulse_o,
  output logic bus_flag_o,
  output logic loc_flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o    <= 1'b0;
      bus_flag_o <= 1'b0;
      loc_flag_o <= 1'b0;
    end else begin
      pulse_o <= bus_hit_i | loc_hit_i;
      if (clr_i) begin
        bus_flag_o <= 1'b0;
        loc_flag_o <= 1'b0;
      end else begin
        if (bus_hit_i) bus_flag_o <= 1'b1;
        if (loc_hit_i) loc_flag_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lin_wake_detector.sv
module lin_wake_detector #(
  parameter int BUS_HOLD_TICKS = 100,
  parameter int DEBOUNCE_TICKS = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sleep_i,
  input  logic standby_i,
  input  logic normal_entry_i,
  input  logic rx_i,
  input  logic wake_pin_i,
  output logic wake_pulse_o,
  output logic bus_wake_o,
  output logic local_wake_o
);
  localparam int HOLD_W = (BUS_HOLD_TICKS < 2) ? 1 : $clog2(BUS_HOLD_TICKS);
  localparam int DEB_W  = (DEBOUNCE_TICKS < 2) ? 1 : $clog2(DEBOUNCE_TICKS);

  logic bus_hit;
  logic loc_hit;

  bus_wake_seq #(.HOLD_TICKS(BUS_HOLD_TICKS), .CW(HOLD_W)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .armed_i (sleep_i | standby_i),
    .rx_i    (rx_i),
    .hit_o   (bus_hit)
  );

  local_wake_filt #(.DEB_TICKS(DEBOUNCE_TICKS), .CW(DEB_W)) u_loc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .armed_i (sleep_i),
    .wake_i  (wake_pin_i),
    .hit_o   (loc_hit)
  );

  wake_flag_reg u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_hit_i  (bus_hit),
    .loc_hit_i  (loc_hit),
    .clr_i      (normal_entry_i),
    .pulse_o    (wake_pulse_o),
    .bus_flag_o (bus_wake_o),
    .loc_flag_o (local_wake_o)
  );
endmodule

// File: rtl/lin_wake_detector_chk.sv
module lin_wake_detector_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_i,
  input logic standby_i,
  input logic normal_entry_i,
  input logic rx_i,
  input logic wake_pulse_o,
  input logic bus_wake_o,
  input logic local_wake_o
);
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |=> !wake_pulse_o); // R11
  AST_PULSE_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_pulse_o && !$past(normal_entry_i)) |-> (bus_wake_o || local_wake_o)); // R2
  AST_BUS_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_wake_o) |-> ($past(rx_i) && $past(sleep_i || standby_i))); // R4
  AST_LOCAL_IN_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(local_wake_o) |-> $past(sleep_i)); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    normal_entry_i |=> (!bus_wake_o && !local_wake_o)); // R10
  AST_BUS_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wake_o && !normal_entry_i) |=> bus_wake_o); // R10
  AST_LOC_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (local_wake_o && !normal_entry_i) |=> local_wake_o); // R10
  AST_RISE_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bus_wake_o) || $rose(local_wake_o)) |-> wake_pulse_o); // R11
endmodule

bind lin_wake_detector lin_wake_detector_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sleep_i        (sleep_i),
  .standby_i      (standby_i),
  .normal_entry_i (normal_entry_i),
  .rx_i           (rx_i),
  .wake_pulse_o   (wake_pulse_o),
  .bus_wake_o     (bus_wake_o),
  .local_wake_o   (local_wake_o)
);

// File: tb/lin_wake_detector_tb_top.sv
module lin_wake_detector_tb_top;
  localparam int H = 20;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic sleep = 1'b0;
  logic standby = 1'b0;
  logic nent = 1'b0;
  logic rx = 1'b1;
  logic wpin = 1'b0;
  logic pulse, bflag, lflag;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  logic ref_m = 1'b0;

  always #10 clk = ~clk;

  lin_wake_detector #(.BUS_HOLD_TICKS(H), .DEBOUNCE_TICKS(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sleep_i(sleep),
    .standby_i(standby), .normal_entry_i(nent), .rx_i(rx),
    .wake_pin_i(wpin), .wake_pulse_o(pulse), .bus_wake_o(bflag),
    .local_wake_o(lflag));

  function automatic logic exp_bus(input int mode, input int len);
    return (mode != 2) && (len >= H + 1);
  endfunction

  function automatic logic exp_loc(input int mode, input int k);
    return (mode == 0) && (k == D + 1);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_mode(input int mode);
    @(negedge clk);
    sleep = (mode == 0);
    standby = (mode == 1);
    @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); nent = 1'b1;
    @(negedge clk); nent = 1'b0;
    chk("R10 bus clear", bflag, 1'b0);
    chk("R10 local clear", lflag, 1'b0);
  endtask

  // dominant for len sampling edges, then release; returns pulse seen
  task automatic bus_pulse(input int len, output logic seen);
    @(negedge clk); rx = 1'b0;
    repeat (len) @(negedge clk);
    rx = 1'b1;
    @(negedge clk);
    seen = pulse;
  endtask

  initial begin
    logic seen;
    void'($urandom(32'h1c3d));
    repeat (3) @(negedge clk);
    chk("R1 pulse", pulse, 1'b0);
    chk("R1 bus flag", bflag, 1'b0);
    chk("R1 local flag", lflag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", pulse | bflag | lflag, 1'b0);

    // R2 / R3 boundary in standby
    set_mode(1);
    bus_pulse(H, seen);
    chk("R3 short dominant", seen, 1'b0);
    chk("R3 no flag", bflag, 1'b0);
    bus_pulse(H + 1, seen);
    chk("R2 min dominant", seen, 1'b1);
    chk("R2 bus flag", bflag, 1'b1);
    chk("R2 no local flag", lflag, 1'b0);
    @(negedge clk);
    chk("R11 pulse drops", pulse, 1'b0);
    repeat (5) @(negedge clk);
    chk("R10 bus flag held", bflag, 1'b1);
    clear_flags();

    // R2 in sleep
    set_mode(0);
    bus_pulse(H + 5, seen);
    chk("R2 sleep bus wake", seen, 1'b1);
    clear_flags();

    // R4 unarmed
    set_mode(2);
    bus_pulse(3 * H, seen);
    chk("R4 unarmed no pulse", seen, 1'b0);
    chk("R4 unarmed no flag", bflag, 1'b0);

    // R5 tick gating
    set_mode(1);
    tick = 1'b0;
    bus_pulse(3 * H, seen);
    chk("R5 no tick no wake", seen, 1'b0);
    tick = 1'b1;

    // R6 dominant already present at arming
    set_mode(2);
    @(negedge clk); rx = 1'b0;
    set_mode(1);
    repeat (2 * H) @(negedge clk);
    rx = 1'b1;
    @(negedge clk);
    chk("R6 no edge no wake", pulse | bflag, 1'b0);

    // R7 local wake rising then falling, in sleep
    set_mode(0);
    ref_m = wpin;
    for (int p = 0; p < 2; p++) begin
      @(negedge clk); wpin = ~ref_m;
      repeat (D) @(negedge clk);
      chk("R7 before debounce", pulse, 1'b0);
      @(negedge clk);
      chk("R7 local pulse", pulse, 1'b1);
      chk("R7 local flag", lflag, 1'b1);
      ref_m = wpin;
      clear_flags();
    end

    // R9 bounce restarts count
    @(negedge clk); wpin = ~ref_m;
    repeat (D) @(negedge clk);
    wpin = ref_m;
    @(negedge clk);
    wpin = ~ref_m;
    repeat (D) @(negedge clk);
    chk("R9 restart no early wake", pulse | lflag, 1'b0);
    @(negedge clk);
    chk("R9 wake after full debounce", pulse, 1'b1);
    ref_m = wpin;
    clear_flags();

    // R8 local ignored in standby, no false wake on sleep entry
    set_mode(1);
    @(negedge clk); wpin = ~wpin;
    repeat (3 * D) @(negedge clk);
    chk("R8 standby ignores wake pin", pulse | lflag, 1'b0);
    set_mode(0);
    repeat (3 * D) @(negedge clk);
    chk("R8 sleep entry no wake", pulse | lflag, 1'b0);
    ref_m = wpin;

    // R10 clear wins over simultaneous wake
    @(negedge clk); rx = 1'b0;
    repeat (H + 2) @(negedge clk);
    rx = 1'b1; nent = 1'b1;
    @(negedge clk); nent = 1'b0;
    chk("R10 clear beats set", bflag, 1'b0);

    // random rounds
    for (int it = 0; it < 40; it++) begin
      int mode;
      int len;
      mode = int'($urandom % 3);
      set_mode(mode);
      if (mode != 0) ref_m = wpin;
      if (it % 2 == 0) begin
        len = H - 4 + int'($urandom % 9);
        bus_pulse(len, seen);
        chk(exp_bus(mode, len) ? "R2 random bus" : "R3 random bus", seen, exp_bus(mode, len));
        chk("R4 random bus flag", bflag, exp_bus(mode, len));
      end else begin
        len = D - 2 + int'($urandom % 5);
        @(negedge clk); wpin = ref_m;
        repeat (2) @(negedge clk);
        wpin = ~ref_m;
        for (int k = 1; k <= len; k++) begin
          @(negedge clk);
          chk(mode == 0 ? "R7 random local" : "R8 random local", pulse, exp_loc(mode, k));
        end
        if (mode != 0 || len >= D + 1) ref_m = wpin;
      end
      clear_flags();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule